// File: doc/BRIEF.md
# Sampling ADC Conversion Controller

This block runs an external 12-bit parallel-output sampling converter from the host side. While `run` is high it issues a start-convert pulse on a programmable period. It watches the converter's end-of-conversion line through a synchronizer. After that line falls it waits a fixed settling delay and then reads the parallel data word. The word is delivered on a valid/ready output stream, either in two's complement or in the converter's native offset binary.

A conversion that is restarted before it finishes gives a corrupt result, so the controller refuses to issue a new start while one is in flight. Each refused request raises a one-cycle `overrun` pulse. A conversion whose end is never signalled is abandoned after a programmable number of cycles and reported on `timeout_err`. The block also drives the converter's active-low output-enable.

Back-pressure on the output stream works as follows. A word on `m_data` stays unchanged while `m_valid` is high and `m_ready` is low. The word is consumed on a clock edge where both are high. The output holds one word. A word captured while that slot is still occupied is discarded, and the held word is kept. The converter cannot be paused, so the stream has no way to stall it.

Top module: `adc_conv_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `adc_start` and `m_valid` are low, `overrun` and `timeout_err` are low, and `adc_oe_n` is high.
- R2: While `run` is high, a start request occurs every `period_cfg` clock cycles, with the first one in the first cycle `run` is seen high. A value of 0 acts as 1.
- R3: Each issued start holds `adc_start` high for exactly `pulse_cfg` cycles. A value of 0 gives a one-cycle pulse.
- R4: No start is issued from the moment one is issued until its word is captured or it times out, nor while the synchronized end-of-conversion line is high. Each request refused for this reason gives a one-cycle `overrun` pulse. With a 20-cycle period and a 40-cycle conversion, starts are therefore 60 cycles apart.
- R5: `adc_eoc` passes through two flops. A detected fall is followed by DATA_DLY (default 2) more cycles, and then `adc_data` is sampled. `m_valid` rises 5 clock edges after the edge that precedes the fall.
- R6: With `raw_mode` low, the output word is the input word with bit 11 inverted (0x800 to 0x000, 0xFFF to 0x7FF, 0x000 to 0x800, 0x7FF to 0xFFF). With `raw_mode` high, the word passes unchanged.
- R7: While `m_valid` is high and `m_ready` is low, `m_data` holds its value. Words captured during that time are dropped, and the next word delivered is the first one captured after the held word was consumed.
- R8: If no end-of-conversion fall arrives, `timeout_err` pulses for one cycle exactly `timeout_cfg` cycles after `adc_start` rises. The conversion is then abandoned, and the following periodic request is issued normally.
- R9: `adc_oe_n` follows `~run` with one register delay.
- R10: A fall of `adc_eoc` when no conversion is in flight produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables periodic conversions and the converter outputs |
| raw_mode | input | 1 | 1: offset-binary output, 0: two's complement |
| period_cfg | input | 16 | Sample period in clock cycles |
| pulse_cfg | input | 8 | Start pulse high time in clock cycles |
| timeout_cfg | input | 16 | Cycles allowed from start to end-of-conversion |
| adc_start | output | 1 | Start-convert pulse to the converter |
| adc_eoc | input | 1 | End-of-conversion from the converter, high while busy |
| adc_data | input | 12 | Parallel data word from the converter |
| adc_oe_n | output | 1 | Active-low output enable to the converter |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | 12 | Output sample |
| overrun | output | 1 | One-cycle pulse: start request refused while busy |
| timeout_err | output | 1 | One-cycle pulse: conversion end not seen in time |

## Verification
Several properties are checked on every cycle: no start rises while a conversion is in flight or the synchronized busy line is high, a held output word stays stable under back-pressure, a new word appears only at the end of a started conversion, a timeout always releases the lockout, and the output-enable follows `run`. The bench scenarios cover the rest. They show the exact start period and pulse width, the capture latency after the end-of-conversion fall, the code conversion across the full-scale extremes, and the dropping of words under back-pressure. They also show the timeout distance, the 60-cycle spacing forced by a slow conversion, and that a stray end-of-conversion is ignored.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic {
    FMT_TWOS = 1'b0,
    FMT_RAW  = 1'b1
  } fmt_e;

  localparam int SYNC_MIN = 2;
endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int STAGES = adc_ctrl_pkg::SYNC_MIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_in,
  output logic eoc_s,
  output logic eoc_fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], eoc_in};
      last <= sh[STAGES-1];
    end
  end

  assign eoc_s    = sh[STAGES-1];
  assign eoc_fall = last & ~sh[STAGES-1];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int PER_W = 16,
  parameter int PUL_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [PUL_W-1:0] pulse_cfg,
  input  logic [TMO_W-1:0] timeout_cfg,
  input  logic             eoc_s,
  input  logic             eoc_fall,
  input  logic             cap_fire,
  output logic             conv_start,
  output logic             arm,
  output logic             busy,
  output logic             overrun,
  output logic             timeout_err
);
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] per_last;
  logic [PUL_W-1:0] pulse_left;
  logic [TMO_W-1:0] to_cnt;
  logic [TMO_W-1:0] to_last;
  logic             tick;
  logic             busy_any;
  logic             issue;

  assign per_last = (period_cfg == '0) ? '0 : period_cfg - 1'b1;
  assign to_last  = (timeout_cfg == '0) ? '0 : timeout_cfg - 1'b1;
  assign tick     = run && (per_cnt == '0);
  assign busy_any = busy | eoc_s;
  assign issue    = tick & ~busy_any;

  // period timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (!run || per_cnt >= per_last) begin
      per_cnt <= '0;
    end else begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  // start pulse, lockout and timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start  <= 1'b0;
      pulse_left  <= '0;
      busy        <= 1'b0;
      arm         <= 1'b0;
      to_cnt      <= '0;
      overrun     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      overrun     <= tick & busy_any;
      timeout_err <= 1'b0;
      if (issue) begin
        conv_start <= 1'b1;
        pulse_left <= (pulse_cfg == '0) ? '0 : pulse_cfg - 1'b1;
        busy       <= 1'b1;
        arm        <= 1'b1;
        to_cnt     <= '0;
      end else begin
        if (pulse_left != '0) begin
          pulse_left <= pulse_left - 1'b1;
        end else begin
          conv_start <= 1'b0;
        end
        if (arm) begin
          if (eoc_fall) begin
            arm <= 1'b0;
          end else if (to_cnt == to_last) begin
            timeout_err <= 1'b1;
            arm         <= 1'b0;
            busy        <= 1'b0;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        if (cap_fire) begin
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int DW       = 12,
  parameter int DATA_DLY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eoc_fall,
  input  logic               arm,
  input  adc_ctrl_pkg::fmt_e fmt,
  input  logic [DW-1:0]      adc_data,
  input  logic               m_ready,
  output logic               cap_fire,
  output logic               m_valid,
  output logic [DW-1:0]      m_data
);
  localparam int CW = $clog2(DATA_DLY + 1);

  logic          dly_act;
  logic [CW-1:0] dly_cnt;
  logic [DW-1:0] word;

  assign cap_fire = dly_act && (dly_cnt == '0);

  generate
    if (DW > 1) begin : g_fmt
      assign word = (fmt == adc_ctrl_pkg::FMT_RAW) ? adc_data
                  : {~adc_data[DW-1], adc_data[DW-2:0]};
    end else begin : g_fmt1
      assign word = (fmt == adc_ctrl_pkg::FMT_RAW) ? adc_data : ~adc_data;
    end
  endgenerate

  // settling delay after the end-of-conversion fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_act <= 1'b0;
      dly_cnt <= '0;
    end else if (eoc_fall && arm) begin
      dly_act <= 1'b1;
      dly_cnt <= CW'(DATA_DLY - 1);
    end else if (dly_act) begin
      if (dly_cnt == '0) begin
        dly_act <= 1'b0;
      end else begin
        dly_cnt <= dly_cnt - 1'b1;
      end
    end
  end

  // one-entry output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (cap_fire && (!m_valid || m_ready)) begin
      m_valid <= 1'b1;
      m_data  <= word;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DW       = 12,
  parameter int PER_W    = 16,
  parameter int PUL_W    = 8,
  parameter int TMO_W    = 16,
  parameter int SYNC_N   = 2,
  parameter int DATA_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             raw_mode,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [PUL_W-1:0] pulse_cfg,
  input  logic [TMO_W-1:0] timeout_cfg,
  output logic             adc_start,
  input  logic             adc_eoc,
  input  logic [DW-1:0]    adc_data,
  output logic             adc_oe_n,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             overrun,
  output logic             timeout_err
);
  logic eoc_s;
  logic eoc_fall;
  logic arm;
  logic conv_busy;
  logic cap_fire;

  adc_eoc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .eoc_in   (adc_eoc),
    .eoc_s    (eoc_s),
    .eoc_fall (eoc_fall)
  );

  adc_conv_seq #(.PER_W(PER_W), .PUL_W(PUL_W), .TMO_W(TMO_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .period_cfg  (period_cfg),
    .pulse_cfg   (pulse_cfg),
    .timeout_cfg (timeout_cfg),
    .eoc_s       (eoc_s),
    .eoc_fall    (eoc_fall),
    .cap_fire    (cap_fire),
    .conv_start  (adc_start),
    .arm         (arm),
    .busy        (conv_busy),
    .overrun     (overrun),
    .timeout_err (timeout_err)
  );

  adc_capture #(.DW(DW), .DATA_DLY(DATA_DLY)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .eoc_fall (eoc_fall),
    .arm      (arm),
    .fmt      (adc_ctrl_pkg::fmt_e'(raw_mode)),
    .adc_data (adc_data),
    .m_ready  (m_ready),
    .cap_fire (cap_fire),
    .m_valid  (m_valid),
    .m_data   (m_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_oe_n <= 1'b1;
    end else begin
      adc_oe_n <= ~run;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          adc_start,
  input logic          eoc_s,
  input logic          conv_busy,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          adc_oe_n,
  input logic          timeout_err
);
  // R4
  start_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_start) |-> (!$past(conv_busy) && !$past(eoc_s)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5
  word_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(conv_busy));

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !conv_busy);

  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> adc_oe_n);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .adc_start   (adc_start),
  .eoc_s       (eoc_s),
  .conv_busy   (conv_busy),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .adc_oe_n    (adc_oe_n),
  .timeout_err (timeout_err)
);

// File: tb/adc_conv_ctrl_test.sv
`timescale 1ns/1ps
module adc_conv_ctrl_test;
  localparam int CLK_PERIOD = 10;

  // {raw input, expected two's complement output}
  localparam logic [23:0] VEC [8] = '{
    24'h800_000, 24'hFFF_7FF, 24'h000_800, 24'h7FF_FFF,
    24'hC00_400, 24'h400_C00, 24'h001_801, 24'hA5A_25A
  };

  function automatic logic [11:0] raw_of(input int k);
    if (k < 8) return VEC[k][23:12];
    return 12'(k * 499 + 167);
  endfunction

  function automatic logic [11:0] tc(input logic [11:0] r);
    return {~r[11], r[10:0]};
  endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic        raw_mode;
  logic [15:0] period_cfg;
  logic [7:0]  pulse_cfg;
  logic [15:0] timeout_cfg;
  logic        adc_start;
  logic        adc_eoc;
  logic [11:0] adc_data;
  logic        adc_oe_n;
  logic        m_valid;
  logic        m_ready;
  logic [11:0] m_data;
  logic        overrun;
  logic        timeout_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .run(run), .raw_mode(raw_mode),
    .period_cfg(period_cfg), .pulse_cfg(pulse_cfg), .timeout_cfg(timeout_cfg),
    .adc_start(adc_start), .adc_eoc(adc_eoc), .adc_data(adc_data),
    .adc_oe_n(adc_oe_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .overrun(overrun), .timeout_err(timeout_err)
  );

  // behavioural converter
  int mi = 0;
  bit mdl_on = 1'b1;
  int conv_cyc = 15;
  bit stray_req = 1'b0;

  initial begin
    bit s_old;
    s_old    = 1'b0;
    adc_eoc  = 1'b0;
    adc_data = 12'h000;
    forever begin
      @(posedge adc_start or stray_req);
      if (stray_req != s_old) begin
        s_old    = stray_req;
        adc_eoc  = 1'b1;
        adc_data = 12'h3C3;
        repeat (10) @(posedge clk);
        #2 adc_eoc = 1'b0;
      end else if (mdl_on) begin
        #(CLK_PERIOD);
        adc_eoc  = 1'b1;
        adc_data = 12'h555;
        repeat (conv_cyc) @(posedge clk);
        #2 adc_eoc = 1'b0;
        #20 adc_data = raw_of(mi);
        mi++;
      end
    end
  end

  // observation of port activity
  int cyc = 0, rise_cyc = 0, intv = 0, width = 0, hi_run = 0;
  int tmo_cyc = 0, ovr_cnt = 0, start_cnt = 0, efall = 0, mvrise = 0;
  bit st_prev = 1'b0, eoc_prev = 1'b0, mv_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (adc_start) begin
      if (!st_prev) begin
        intv     = cyc - rise_cyc;
        rise_cyc = cyc;
        start_cnt++;
        hi_run   = 1;
      end else begin
        hi_run++;
      end
    end else if (st_prev) begin
      width = hi_run;
    end
    st_prev = adc_start;
    if (!adc_eoc && eoc_prev) efall = cyc;
    eoc_prev = adc_eoc;
    if (m_valid && !mv_prev) mvrise = cyc;
    mv_prev = m_valid;
    if (timeout_err) tmo_cyc = cyc;
    if (overrun) ovr_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic get_word(output logic [11:0] w);
    int n;
    n = 0;
    while (!m_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (m_valid) w = m_data;
    else         w = 'x;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic stop_drain();
    run     = 1'b0;
    m_ready = 1'b1;
    repeat (200) @(negedge clk);
    m_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] w;
    int base, s0, o0, n;
    rst_n = 1'b0; run = 1'b0; raw_mode = 1'b0; m_ready = 1'b0;
    period_cfg = 16'd40; pulse_cfg = 8'd5; timeout_cfg = 16'd200;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 start", adc_start, 0);
    check("R1 valid", m_valid, 0);
    check("R1 overrun", overrun, 0);
    check("R1 timeout", timeout_err, 0);
    check("R1 oe_n", adc_oe_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 start after reset", adc_start, 0);

    // main table: two's complement conversion
    run = 1'b1;
    @(negedge clk);
    check("R9 oe_n low while running", adc_oe_n, 0);
    for (int i = 0; i < 8; i++) begin
      get_word(w);
      check($sformatf("R6 word %0d", i), w, VEC[i][11:0]);
    end
    check("R5 capture latency", mvrise - efall, 5);
    check("R2 period", intv, 40);
    check("R3 pulse width", width, 5);
    stop_drain();
    check("R9 oe_n high when stopped", adc_oe_n, 1);

    // R6 raw mode
    raw_mode = 1'b1;
    base = mi;
    run = 1'b1;
    get_word(w);
    check("R6 raw passthrough", w, raw_of(base));
    stop_drain();
    raw_mode = 1'b0;

    // R7 back-pressure
    base = mi;
    run = 1'b1;
    n = 0;
    while (mi < base + 3 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check("R7 held valid", m_valid, 1);
    check("R7 held data", m_data, tc(raw_of(base)));
    get_word(w);
    check("R7 first word", w, tc(raw_of(base)));
    get_word(w);
    check("R7 next word after drops", w, tc(raw_of(base + 3)));
    stop_drain();

    // R4 slow conversion forces lockout
    period_cfg = 16'd20;
    conv_cyc = 40;
    o0 = ovr_cnt;
    base = mi;
    run = 1'b1;
    get_word(w);
    check("R4 word 0", w, tc(raw_of(base)));
    get_word(w);
    check("R4 word 1", w, tc(raw_of(base + 1)));
    check("R4 overrun seen", (ovr_cnt > o0), 1);
    check("R4 start spacing", intv, 60);
    stop_drain();
    conv_cyc = 15;

    // R8 timeout
    mdl_on = 1'b0;
    period_cfg = 16'd100;
    timeout_cfg = 16'd25;
    s0 = start_cnt;
    run = 1'b1;
    repeat (150) @(negedge clk);
    check("R8 timeout distance", tmo_cyc - rise_cyc, 25);
    check("R8 restart after timeout", start_cnt - s0, 2);
    check("R8 no word", m_valid, 0);
    run = 1'b0;
    repeat (200) @(negedge clk);
    mdl_on = 1'b1;
    timeout_cfg = 16'd200;
    period_cfg = 16'd40;

    // R10 stray end-of-conversion
    stray_req = ~stray_req;
    repeat (60) @(negedge clk);
    check("R10 stray ignored", m_valid, 0);

    // R3 zero width acts as one
    pulse_cfg = 8'd0;
    base = mi;
    run = 1'b1;
    get_word(w);
    check("R3 pulse width zero", width, 1);
    check("R6 after zero width", w, tc(raw_of(base)));
    stop_drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule